// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block collects every reset request in a device and turns each one into one of three sequences. A power-on sequence starts whenever the asynchronous power-good input goes low. A hard sequence starts on the external hard-reset pin, a watchdog expiry (only while its enable bit is set), a serial-link reset request or a software hard-reset bit. A soft sequence starts on the external soft-reset pin, a host-reset command from the test port or a software soft-reset bit. The classes differ in what they touch. Power-on and hard sequences pull both open-drain reset pins low and ask for a configuration sample. Only power-on asks for the configuration word to be loaded. A soft sequence pulls only the soft pin and leaves configuration untouched. All three hold the processing cores in reset.

The sequencer is a five-state machine. `ST_POR` holds power-on for `POR_CYC` cycles. `ST_HARD` holds a hard sequence for `HARD_CYC` cycles. `ST_SOFT` holds a soft sequence for `SOFT_CYC` cycles. `ST_REL` has released the pins and waits for both of them to read back as released. `ST_RUN` is normal operation. The transitions are:
- POR→REL and HARD→REL when the count expires.
- RUN→HARD on any hard request.
- RUN→SOFT on a soft request when no hard request is present.
- SOFT→HARD on a hard request that arrives during a soft sequence (escalation).
- SOFT→REL when the count expires.
- REL→RUN when both synchronized pins read high.
- Any state→POR when power-good drops.

Software sees two 8-bit registers. The control register holds the self-clearing reset bits and the watchdog enable. The sticky status register records the sources behind each sequence, and its bits are cleared by writing 1.

Top module: `reset_sequencer`

## Requirements
- R1: While `por_n_i` is low, the block asynchronously drives both pins, holds the cores in reset, clears the control register to 0 and sets the status register to 0x01. After `por_n_i` rises, a two-flop synchronizer delays the release. Power-on then lasts `POR_CYC` cycles, and `cfg_load_o` and `cfg_sample_o` pulse together in its last cycle. `cfg_load_o` never rises at any other time.
- R2: A hard request is one of: a synchronized low on `hard_pin_i`, `wdog_zero_i` while control bit 2 is set, `link_hard_i`, or control bit 0. In `ST_RUN` it starts a hard sequence. Both pin drives are high and the cores are held for `HARD_CYC` cycles, with a `cfg_sample_o` pulse in the last cycle.
- R3: A soft request is one of: a synchronized low on `soft_pin_i`, `tap_host_i`, or control bit 1. In `ST_RUN`, with no hard request present, it starts a soft sequence. Only the soft pin is driven and the cores are held for `SOFT_CYC` cycles, with no configuration pulse. Whenever the hard pin is driven, the soft pin is driven too.
- R4: A low on `soft_pin_i` is ignored unless the state is `ST_RUN`. The block never treats a pin it is driving as a new request.
- R5: Hard requests take priority over soft requests in the same cycle. A hard request during a soft sequence switches at once to a full hard sequence.
- R6: When the count expires, both pin drives are released. `core_rst_n_o` rises only after both synchronized pins read high.
- R7: Status bits, set at the start of a sequence for each active source of the class that won: 0 power-on, 1 external hard pin, 2 external soft pin, 3 watchdog, 4 serial link, 5 test-port host reset, 6 software hard, 7 software soft. The bits are sticky.
- R8: Writing 1 to a status bit clears it. A bit that is set by a sequence start in the same cycle stays 1.
- R9: Control bit 0 clears when a hard sequence starts. Bit 1 clears when either a hard or a soft sequence starts. A register write in that same cycle takes precedence. With bit 2 low, `wdog_zero_i` has no effect.
- R10: When `reg_addr_i`=0, `reg_rdata_o` reads {5'b0, wdog_en, sw_soft, sw_hard}. When `reg_addr_i`=1, it reads the status register. The read path is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Asynchronous power-good, low starts power-on |
| hard_pin_i | input | 1 | Sensed level of the open-drain hard-reset pin (low = asserted) |
| soft_pin_i | input | 1 | Sensed level of the open-drain soft-reset pin (low = asserted) |
| wdog_zero_i | input | 1 | Watchdog count reached zero |
| link_hard_i | input | 1 | Serial-link hard-reset request |
| tap_host_i | input | 1 | Test-port host-reset command |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = control, 1 = status |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data |
| hard_pin_drive_o | output | 1 | Pull the hard-reset pin low |
| soft_pin_drive_o | output | 1 | Pull the soft-reset pin low |
| core_rst_n_o | output | 1 | Core reset, active low |
| cfg_sample_o | output | 1 | Sample system configuration |
| cfg_load_o | output | 1 | Select source and load the configuration word |

## Verification
A software write to the status register can land in the same cycle as the start of a sequence that records a source in that same register. The bench provokes this by pulsing `tap_host_i` and, in that same cycle, writing 1 to bit 5 of the status register. It expects bit 5 to read 1 afterwards, because the recorded source wins over the clear. The same kind of overlap is provoked on the control register: the software hard bit is rewritten in the very cycle its sequence starts, and a second hard sequence is expected to follow the first.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_POR  = 3'd0,
        ST_HARD = 3'd1,
        ST_SOFT = 3'd2,
        ST_REL  = 3'd3,
        ST_RUN  = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic xhard;
        logic wdog;
        logic link;
        logic swhard;
        logic xsoft;
        logic tap;
        logic swsoft;
    } rst_req_t;

    localparam int REG_W     = 8;
    localparam int CTRL_W    = 3;
    localparam int CB_SWHARD = 0;
    localparam int CB_SWSOFT = 1;
    localparam int CB_WDEN   = 2;

    localparam int SB_POR    = 0;
    localparam int SB_XHARD  = 1;
    localparam int SB_XSOFT  = 2;
    localparam int SB_WDOG   = 3;
    localparam int SB_LINK   = 4;
    localparam int SB_TAP    = 5;
    localparam int SB_SWHARD = 6;
    localparam int SB_SWSOFT = 7;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             arst_n_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge arst_n_i) begin
                if (!arst_n_i) stg_q[s] <= RST_VAL;
                else           stg_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge arst_n_i) begin
                if (!arst_n_i) stg_q[s] <= RST_VAL;
                else           stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/rstseq_regs.sv
module rstseq_regs
    import rstseq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              wr_i,
    input  logic              addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  rst_req_t          req_i,
    input  logic              start_hard_i,
    input  logic              start_soft_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [REG_W-1:0]  rdata_o
);

    logic [CTRL_W-1:0] ctrl_q;
    logic [REG_W-1:0]  stat_q;
    logic [REG_W-1:0]  set_mask;
    logic [REG_W-1:0]  stat_d;

    always_comb begin
        set_mask = '0;
        if (start_hard_i) begin
            set_mask[SB_XHARD]  = req_i.xhard;
            set_mask[SB_WDOG]   = req_i.wdog;
            set_mask[SB_LINK]   = req_i.link;
            set_mask[SB_SWHARD] = req_i.swhard;
        end else if (start_soft_i) begin
            set_mask[SB_XSOFT]  = req_i.xsoft;
            set_mask[SB_TAP]    = req_i.tap;
            set_mask[SB_SWSOFT] = req_i.swsoft;
        end
    end

    always_comb begin
        stat_d = stat_q;
        if (wr_i && addr_i) stat_d = stat_d & ~wdata_i;
        stat_d = stat_d | set_mask;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            stat_q <= REG_W'(1) << SB_POR;
        end else begin
            stat_q <= stat_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            ctrl_q <= '0;
        end else if (wr_i && !addr_i) begin
            ctrl_q <= wdata_i[CTRL_W-1:0];
        end else begin
            if (start_hard_i) begin
                ctrl_q[CB_SWHARD] <= 1'b0;
                ctrl_q[CB_SWSOFT] <= 1'b0;
            end
            if (start_soft_i) ctrl_q[CB_SWSOFT] <= 1'b0;
        end
    end

    assign ctrl_o  = ctrl_q;
    assign rdata_o = addr_i ? stat_q : {{(REG_W-CTRL_W){1'b0}}, ctrl_q};

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int POR_CYC  = 32,
    parameter int HARD_CYC = 64,
    parameter int SOFT_CYC = 16
) (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  rst_req_t   req_i,
    input  logic       pins_free_i,
    output seq_state_t state_o,
    output logic       start_hard_o,
    output logic       start_soft_o,
    output logic       hard_drv_o,
    output logic       soft_drv_o,
    output logic       core_rst_n_o,
    output logic       cfg_sample_o,
    output logic       cfg_load_o
);

    localparam int MAX_HS  = (HARD_CYC > SOFT_CYC) ? HARD_CYC : SOFT_CYC;
    localparam int MAX_CYC = (POR_CYC > MAX_HS) ? POR_CYC : MAX_HS;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             hard_any, soft_any, cnt_zero;

    assign hard_any = req_i.xhard | req_i.wdog | req_i.link | req_i.swhard;
    assign soft_any = req_i.xsoft | req_i.tap  | req_i.swsoft;
    assign cnt_zero = (cnt_q == '0);

    // next state
    always_comb begin
        state_d      = state_q;
        start_hard_o = 1'b0;
        start_soft_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (hard_any) begin
                    state_d      = ST_HARD;
                    start_hard_o = 1'b1;
                end else if (soft_any) begin
                    state_d      = ST_SOFT;
                    start_soft_o = 1'b1;
                end
            end
            ST_SOFT: begin
                if (hard_any) begin
                    state_d      = ST_HARD;
                    start_hard_o = 1'b1;
                end else if (cnt_zero) begin
                    state_d = ST_REL;
                end
            end
            ST_POR, ST_HARD: begin
                if (cnt_zero) state_d = ST_REL;
            end
            ST_REL: begin
                if (pins_free_i) state_d = ST_RUN;
            end
            default: state_d = ST_POR;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= ST_POR;
        else          state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)          cnt_q <= CNT_W'(POR_CYC - 1);
        else if (start_hard_o) cnt_q <= CNT_W'(HARD_CYC - 1);
        else if (start_soft_o) cnt_q <= CNT_W'(SOFT_CYC - 1);
        else if (!cnt_zero)    cnt_q <= cnt_q - 1'b1;
    end

    // outputs
    always_comb begin
        hard_drv_o   = 1'b0;
        soft_drv_o   = 1'b0;
        core_rst_n_o = 1'b0;
        cfg_sample_o = 1'b0;
        cfg_load_o   = 1'b0;
        unique case (state_q)
            ST_POR: begin
                hard_drv_o   = 1'b1;
                soft_drv_o   = 1'b1;
                cfg_sample_o = cnt_zero;
                cfg_load_o   = cnt_zero;
            end
            ST_HARD: begin
                hard_drv_o   = 1'b1;
                soft_drv_o   = 1'b1;
                cfg_sample_o = cnt_zero;
            end
            ST_SOFT: soft_drv_o   = 1'b1;
            ST_REL:  core_rst_n_o = 1'b0;
            ST_RUN:  core_rst_n_o = 1'b1;
            default: core_rst_n_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int POR_CYC     = 32,
    parameter int HARD_CYC    = 64,
    parameter int SOFT_CYC    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             por_n_i,
    input  logic             hard_pin_i,
    input  logic             soft_pin_i,
    input  logic             wdog_zero_i,
    input  logic             link_hard_i,
    input  logic             tap_host_i,
    input  logic             reg_wr_i,
    input  logic             reg_addr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             hard_pin_drive_o,
    output logic             soft_pin_drive_o,
    output logic             core_rst_n_o,
    output logic             cfg_sample_o,
    output logic             cfg_load_o
);

    logic              rst_n_q;
    logic [1:0]        pins_q;
    logic [CTRL_W-1:0] ctrl;
    rst_req_t          req;
    seq_state_t        state_q;
    logic              start_hard, start_soft;

    rstseq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_por_sync (
        .clk_i   (clk_i),
        .arst_n_i(por_n_i),
        .d_i     (1'b1),
        .q_o     (rst_n_q)
    );

    rstseq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_pin_sync (
        .clk_i   (clk_i),
        .arst_n_i(rst_n_q),
        .d_i     ({hard_pin_i, soft_pin_i}),
        .q_o     (pins_q)
    );

    always_comb begin
        req.xhard  = !pins_q[1];
        req.wdog   = wdog_zero_i & ctrl[CB_WDEN];
        req.link   = link_hard_i;
        req.swhard = ctrl[CB_SWHARD];
        req.xsoft  = !pins_q[0];
        req.tap    = tap_host_i;
        req.swsoft = ctrl[CB_SWSOFT];
    end

    rstseq_fsm #(.POR_CYC(POR_CYC), .HARD_CYC(HARD_CYC), .SOFT_CYC(SOFT_CYC)) u_fsm (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_q),
        .req_i       (req),
        .pins_free_i (&pins_q),
        .state_o     (state_q),
        .start_hard_o(start_hard),
        .start_soft_o(start_soft),
        .hard_drv_o  (hard_pin_drive_o),
        .soft_drv_o  (soft_pin_drive_o),
        .core_rst_n_o(core_rst_n_o),
        .cfg_sample_o(cfg_sample_o),
        .cfg_load_o  (cfg_load_o)
    );

    rstseq_regs u_regs (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_q),
        .wr_i        (reg_wr_i),
        .addr_i      (reg_addr_i),
        .wdata_i     (reg_wdata_i),
        .req_i       (req),
        .start_hard_i(start_hard),
        .start_soft_i(start_soft),
        .ctrl_o      (ctrl),
        .rdata_o     (reg_rdata_o)
    );

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk
    import rstseq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input seq_state_t        state,
    input logic [CTRL_W-1:0] ctrl,
    input logic [1:0]        pins,
    input logic              hard_drv,
    input logic              soft_drv,
    input logic              core_n,
    input logic              sample,
    input logic              load
);

    assert_hard_forces_soft_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hard_drv |-> soft_drv);

    assert_load_only_por_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (state == ST_POR) && sample);

    assert_sample_with_hard_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> hard_drv);

    assert_release_after_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_n) |-> $past(pins) == 2'b11);

    assert_swhard_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && ctrl[CB_SWHARD]) |=> (state == ST_HARD) && hard_drv);

    assert_soft_only_from_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN && state != ST_SOFT) |=> state != ST_SOFT);

    assert_escalate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SOFT && ctrl[CB_SWHARD]) |=> state == ST_HARD);

endmodule

bind reset_sequencer rstseq_chk u_chk (
    .clk     (clk_i),
    .rst_n   (rst_n_q),
    .state   (state_q),
    .ctrl    (ctrl),
    .pins    (pins_q),
    .hard_drv(hard_pin_drive_o),
    .soft_drv(soft_pin_drive_o),
    .core_n  (core_rst_n_o),
    .sample  (cfg_sample_o),
    .load    (cfg_load_o)
);

// File: tb/reset_sequencer_tb_top.sv
module reset_sequencer_tb_top;

    localparam int POR_C  = 32;
    localparam int HARD_C = 64;
    localparam int SOFT_C = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       por_n = 1'b0, ext_h = 1'b0, ext_s = 1'b0;
    logic       wdog = 1'b0, link = 1'b0, tap = 1'b0;
    logic       wr = 1'b0, addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       hdrv, sdrv, core_n, smp, ld;
    wire        hard_pin = !(hdrv || ext_h);
    wire        soft_pin = !(sdrv || ext_s);

    reset_sequencer #(.POR_CYC(POR_C), .HARD_CYC(HARD_C), .SOFT_CYC(SOFT_C)) dut_i (
        .clk_i(clk), .por_n_i(por_n), .hard_pin_i(hard_pin), .soft_pin_i(soft_pin),
        .wdog_zero_i(wdog), .link_hard_i(link), .tap_host_i(tap),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .hard_pin_drive_o(hdrv), .soft_pin_drive_o(sdrv), .core_rst_n_o(core_n),
        .cfg_sample_o(smp), .cfg_load_o(ld)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit checking = 0;

    // behavioural reference: mode 0 power-on, 1 hard, 2 soft, 3 release wait, 4 run
    int         m_st, m_cnt;
    logic [1:0] m_rs, m_hs, m_ss;
    logic [2:0] m_ctrl;
    logic [7:0] m_stat;
    wire m_hd   = (m_st == 0) || (m_st == 1);
    wire m_sd   = (m_st <= 2);
    wire m_core = (m_st == 4);
    wire m_smp  = (m_st <= 1) && (m_cnt == 0);
    wire m_ld   = (m_st == 0) && (m_cnt == 0);

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_rs <= 2'b00; m_st <= 0; m_cnt <= POR_C - 1;
            m_ctrl <= 3'b000; m_stat <= 8'h01; m_hs <= 2'b11; m_ss <= 2'b11;
        end else if (!m_rs[1]) begin
            m_rs <= {m_rs[0], 1'b1};
        end else begin : step
            int nst, ncnt;
            logic [2:0] nctrl;
            logic [7:0] nstat;
            bit hreq, sreq, go_h, go_s;
            hreq = !m_hs[1] || (wdog && m_ctrl[2]) || link || m_ctrl[0];
            sreq = !m_ss[1] || tap || m_ctrl[1];
            nst = m_st; ncnt = (m_cnt > 0) ? m_cnt - 1 : 0; go_h = 0; go_s = 0;
            case (m_st)
                4: if (hreq) go_h = 1; else if (sreq) go_s = 1;
                2: if (hreq) go_h = 1; else if (m_cnt == 0) nst = 3;
                0, 1: if (m_cnt == 0) nst = 3;
                3: if (m_hs[1] && m_ss[1]) nst = 4;
                default: nst = 0;
            endcase
            if (go_h) begin nst = 1; ncnt = HARD_C - 1; end
            else if (go_s) begin nst = 2; ncnt = SOFT_C - 1; end
            nctrl = m_ctrl;
            if (go_h) nctrl[1:0] = 2'b00;
            if (go_s) nctrl[1] = 1'b0;
            if (wr && !addr) nctrl = wdata[2:0];
            nstat = m_stat;
            if (wr && addr) nstat = nstat & ~wdata;
            if (go_h) begin
                nstat[1] = nstat[1] | !m_hs[1];
                nstat[3] = nstat[3] | (wdog && m_ctrl[2]);
                nstat[4] = nstat[4] | link;
                nstat[6] = nstat[6] | m_ctrl[0];
            end
            if (go_s) begin
                nstat[2] = nstat[2] | !m_ss[1];
                nstat[5] = nstat[5] | tap;
                nstat[7] = nstat[7] | m_ctrl[1];
            end
            m_st <= nst; m_cnt <= ncnt; m_ctrl <= nctrl; m_stat <= nstat;
            m_hs <= {m_hs[0], !(m_hd || ext_h)};
            m_ss <= {m_ss[0], !(m_sd || ext_s)};
        end
    end

    function automatic void chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (checking) begin
            chk("R2", "hard pin drive", {7'b0, hdrv}, {7'b0, m_hd});
            chk("R3", "soft pin drive", {7'b0, sdrv}, {7'b0, m_sd});
            chk("R6", "core reset", {7'b0, core_n}, {7'b0, m_core});
            chk("R2", "config sample", {7'b0, smp}, {7'b0, m_smp});
            chk("R1", "config load", {7'b0, ld}, {7'b0, m_ld});
            chk("R10", "read data", rdata, addr ? m_stat : {5'b0, m_ctrl});
        end
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d actual=running expected=done", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic wreg(input logic a, input logic [7:0] d);
        tick(); wr = 1'b1; addr = a; wdata = d;
        tick(); wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        tick(); addr = a;
        @(negedge clk); v = rdata;
    endtask

    task automatic wait_run();
        repeat (4) begin tick(); addr = ~addr; end
        for (int i = 0; i < 400 && m_st != 4; i++) begin tick(); addr = ~addr; end
        repeat (2) begin tick(); addr = ~addr; end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin tick(); addr = ~addr; end
    endtask

    logic [7:0] v;

    initial begin
        repeat (2) tick();
        checking = 1;
        repeat (3) tick();
        por_n = 1'b1;
        wait_run();
        rd(1'b1, v); chk("R1", "status after power-on", v, 8'h01);
        rd(1'b0, v); chk("R10", "control after power-on", v, 8'h00);

        wreg(1'b1, 8'hFF);
        rd(1'b1, v); chk("R8", "status after write-one clear", v, 8'h00);

        wreg(1'b0, 8'h01); wait_run();
        rd(1'b0, v); chk("R9", "software hard bit self-clear", v, 8'h00);
        rd(1'b1, v); chk("R7", "status software hard", v, 8'h40);

        wreg(1'b0, 8'h02); wait_run();
        rd(1'b1, v); chk("R3", "status software soft", v, 8'hC0);

        tick(); wdog = 1'b1; tick(); wdog = 1'b0;
        idle(10);
        @(negedge clk); chk("R9", "watchdog ignored when disabled", {7'b0, core_n}, 8'h01);
        rd(1'b1, v); chk("R9", "status unchanged by disabled watchdog", v, 8'hC0);

        wreg(1'b0, 8'h04);
        tick(); wdog = 1'b1; tick(); wdog = 1'b0;
        wait_run();
        rd(1'b1, v); chk("R2", "status watchdog", v, 8'hC8);

        wreg(1'b1, 8'hFF);
        tick(); link = 1'b1; tick(); link = 1'b0; wait_run();
        tick(); tap = 1'b1; tick(); tap = 1'b0; wait_run();
        rd(1'b1, v); chk("R7", "status link then tap", v, 8'h30);

        wreg(1'b1, 8'hFF);
        tick(); ext_h = 1'b1; repeat (3) tick(); ext_h = 1'b0; wait_run();
        rd(1'b1, v); chk("R2", "status external hard", v, 8'h02);

        wreg(1'b1, 8'hFF);
        tick(); ext_s = 1'b1; repeat (3) tick(); ext_s = 1'b0; wait_run();
        rd(1'b1, v); chk("R3", "status external soft", v, 8'h04);

        wreg(1'b1, 8'hFF);
        tick(); link = 1'b1; tick(); link = 1'b0;
        idle(5); ext_s = 1'b1; idle(10); ext_s = 1'b0;
        wait_run(); idle(10);
        rd(1'b1, v); chk("R4", "soft pin ignored during hard", v, 8'h10);
        @(negedge clk); chk("R4", "cores running after ignored soft pin", {7'b0, core_n}, 8'h01);

        wreg(1'b1, 8'hFF);
        tick(); link = 1'b1; tap = 1'b1; tick(); link = 1'b0; tap = 1'b0; wait_run();
        rd(1'b1, v); chk("R5", "hard wins same cycle", v, 8'h10);

        wreg(1'b1, 8'hFF);
        tick(); tap = 1'b1; tick(); tap = 1'b0;
        idle(5); link = 1'b1; tick(); link = 1'b0; wait_run();
        rd(1'b1, v); chk("R5", "escalation soft to hard", v, 8'h30);

        wreg(1'b1, 8'hFF);
        tick(); tap = 1'b1; wr = 1'b1; addr = 1'b1; wdata = 8'h20;
        tick(); tap = 1'b0; wr = 1'b0; wait_run();
        rd(1'b1, v); chk("R8", "set wins over same-cycle clear", v, 8'h20);

        tick(); wr = 1'b1; addr = 1'b0; wdata = 8'h05;
        tick(); tick(); wr = 1'b0;
        rd(1'b0, v); chk("R9", "write wins over self-clear", v, 8'h05);
        idle(200); wait_run();
        rd(1'b0, v); chk("R9", "control after second hard", v, 8'h04);

        tick(); tap = 1'b1; tick(); tap = 1'b0; idle(5);
        por_n = 1'b0; repeat (3) tick(); por_n = 1'b1;
        wait_run();
        rd(1'b1, v); chk("R1", "status after mid-sequence power-on", v, 8'h01);
        rd(1'b0, v); chk("R1", "control after mid-sequence power-on", v, 8'h00);

        idle(3);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule